// File: doc/BRIEF.md
# Instruction Prefetch Queue with Transfer Flush

This block keeps a small FIFO of code bytes fetched ahead of the instruction pointer. It sits between a word-wide memory fetch port and a byte-wide consumer such as an execution unit. The fetch address is built from a code segment register and a prefetch offset. While enough byte slots are free, the block requests the next word and adds the returned bytes to the queue. The consumer therefore usually finds its next byte already waiting.

When a program transfer arrives carrying a new segment and offset, the queued bytes are stale. The block discards all of them and reloads its address registers. Fetching then restarts from the new target. While the queue is empty, the first byte that memory returns goes straight to the consumer in the same cycle, and the remaining bytes refill the queue.

Top module: `prefetch_queue`

## Requirements
- R1: During and right after reset, the queue is empty and `out_valid` is 0. `fetch_req` is 1 and `fetch_addr` equals RESET_SEG*16 + RESET_OFS.
- R2: `fetch_addr` is always (segment << 4) + offset, truncated to ADDR_W bits. It does not change while a request waits for `fetch_rdy`.
- R3: `fetch_req` is 1 only when at least 2 of the DEPTH byte slots are free and no transfer is present. The queue never holds more than DEPTH bytes.
- R4: A fetch is accepted in a cycle where `fetch_req` and `fetch_rdy` are both 1. An accepted fetch from an even offset yields `fetch_data[7:0]` first and then `fetch_data[15:8]`, and the offset advances by 2.
- R5: An accepted fetch from an odd offset yields only `fetch_data[15:8]`, and the offset advances by 1, so that later fetches are word aligned.
- R6: Bytes reach the consumer in exactly the order of their fetch addresses, with none lost or repeated.
- R7: In a cycle with `xfer_valid` = 1, `out_valid` and `fetch_req` are 0 and all queued bytes are discarded. From the next cycle, fetching starts at `xfer_seg`*16 + `xfer_ofs`.
- R8: Data presented with `fetch_rdy` in the same cycle as a transfer is dropped and never reaches the consumer.
- R9: When the queue is empty, an accepted fetch presents its first byte on `out_byte` with `out_valid` = 1 in that same cycle.
- R10: A byte offered with `out_valid` = 1 is taken only in a cycle with `out_ready` = 1. Otherwise it stays at the head of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | Program transfer strobe |
| xfer_seg | input | SEG_W | New code segment |
| xfer_ofs | input | OFS_W | New instruction offset |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | ADDR_W | Physical fetch address |
| fetch_data | input | 16 | Word returned by memory |
| fetch_rdy | input | 1 | Memory completes the request this cycle |
| out_valid | output | 1 | A code byte is offered |
| out_byte | output | 8 | Offered code byte |
| out_ready | input | 1 | Consumer takes the byte |

## Verification
The bench builds the block with its default parameters: a 6-byte queue, a 16-bit segment and offset, and a 20-bit address. With a depth this small, a stalled consumer fills the queue within a few cycles. That makes the free-slot rule for requests, and the single-byte gap it leaves, easy to reach. Transfer targets include odd and even offsets and a segment and offset pair that wraps past the 20-bit limit. One transfer coincides with a memory completion, so the odd-byte path, the address wrap and the drop of in-flight data all occur many times.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef logic [7:0] byte_t;

  // circular index add for a non-power-of-two ring
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned depth);
    int unsigned s;
    s = base + off;
    if (s >= depth) s = s - depth;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/pfq_ring.sv
module pfq_ring
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             pop,
  input  logic [1:0]       push_n,
  input  byte_t            push_b0,
  input  byte_t            push_b1,
  output byte_t            head,
  output logic [CNT_W-1:0] count
);
  byte_t            slot_q [DEPTH];
  logic [IDX_W-1:0] rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] wr0, wr1;

  always_comb begin
    wr0 = IDX_W'(ring_add(int'(rd_q), int'(cnt_q), DEPTH));
    wr1 = IDX_W'(ring_add(int'(rd_q), int'(cnt_q) + 1, DEPTH));
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else begin
      if (pop) rd_d = IDX_W'(ring_add(int'(rd_q), 1, DEPTH));
      cnt_d = cnt_q + CNT_W'(push_n) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic  we;
    byte_t wd;
    always_comb begin
      we = 1'b0;
      wd = push_b0;
      if (!flush && push_n != 2'd0 && wr0 == IDX_W'(i)) begin
        we = 1'b1;
        wd = push_b0;
      end else if (!flush && push_n == 2'd2 && wr1 == IDX_W'(i)) begin
        we = 1'b1;
        wd = push_b1;
      end
    end
    always_ff @(posedge clk) begin
      if (we) slot_q[i] <= wd;
    end
  end

  assign head  = slot_q[rd_q];
  assign count = cnt_q;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/pfq_addr.sv
module pfq_addr #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFS_W-1:0] RESET_OFS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEG_W-1:0]  load_seg,
  input  logic [OFS_W-1:0]  load_ofs,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              odd
);
  logic [SEG_W-1:0] seg_q, seg_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;

  always_comb begin
    seg_d = seg_q;
    ofs_d = ofs_q;
    if (load) begin
      seg_d = load_seg;
      ofs_d = load_ofs;
    end else if (adv) begin
      ofs_d = ofs_q + (ofs_q[0] ? OFS_W'(1) : OFS_W'(2));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= RESET_SEG;
      ofs_q <= RESET_OFS;
    end else begin
      seg_q <= seg_d;
      ofs_q <= ofs_d;
    end
  end

  assign addr = (ADDR_W'(seg_q) << SHIFT) + ADDR_W'(ofs_q);
  assign odd  = ofs_q[0];

  a_r5_odd_aligns: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && ofs_q[0] |=> !ofs_q[0]);
  a_r4_even_stays: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && !ofs_q[0] |=> !ofs_q[0]);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int ADDR_W = 20,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFS_W-1:0] RESET_OFS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  input  logic [SEG_W-1:0]  xfer_seg,
  input  logic [OFS_W-1:0]  xfer_ofs,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [15:0]       fetch_data,
  input  logic              fetch_rdy,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  input  logic              out_ready
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0] count;
  byte_t            head;
  logic             odd, accept, q_empty, take, bypass, pop;
  byte_t            ret_b0, ret_b1, push_b0, push_b1;
  logic [1:0]       ret_n, push_n;

  pfq_addr #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .SHIFT(4),
    .RESET_SEG(RESET_SEG), .RESET_OFS(RESET_OFS)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(xfer_valid), .load_seg(xfer_seg), .load_ofs(xfer_ofs),
    .adv(accept), .addr(fetch_addr), .odd(odd)
  );

  always_comb begin
    fetch_req = (count <= ROOM_MAX) && !xfer_valid;
    accept    = fetch_req && fetch_rdy;
    ret_b0    = odd ? fetch_data[15:8] : fetch_data[7:0];
    ret_b1    = fetch_data[15:8];
    ret_n     = odd ? 2'd1 : 2'd2;
    q_empty   = (count == '0);
    out_valid = !xfer_valid && (!q_empty || accept);
    out_byte  = q_empty ? ret_b0 : head;
    take      = out_valid && out_ready;
    bypass    = q_empty && take;
    pop       = take && !q_empty;
    push_n    = 2'd0;
    push_b0   = ret_b0;
    push_b1   = ret_b1;
    if (bypass) begin
      push_n  = ret_n - 2'd1;
      push_b0 = ret_b1;
    end else if (accept) begin
      push_n  = ret_n;
    end
  end

  pfq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(xfer_valid), .pop(pop),
    .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
    .head(head), .count(count)
  );

  a_r3_req_room: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> count <= ROOM_MAX);
  a_r7_quiet_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !out_valid && !fetch_req);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_rdy |=> xfer_valid || $stable(fetch_addr));
  a_r9_bypass_src: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_empty |-> fetch_rdy);
endmodule

// File: tb/prefetch_queue_tb.sv
`timescale 1ns/1ps
module prefetch_queue_tb;
  localparam int DEPTH = 6;
  logic clk = 1'b0;
  logic rst_n;
  logic xfer_valid, fetch_rdy, out_ready;
  logic [15:0] xfer_seg, xfer_ofs, fetch_data;
  logic fetch_req, out_valid;
  logic [19:0] fetch_addr;
  logic [7:0] out_byte;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prefetch_queue u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_seg(xfer_seg),
    .xfer_ofs(xfer_ofs), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .fetch_rdy(fetch_rdy), .out_valid(out_valid),
    .out_byte(out_byte), .out_ready(out_ready)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return 8'((a * 37) ^ (a >> 7) ^ 20'h5a);
  endfunction

  // memory returns the aligned word containing the address
  always_comb fetch_data = {mem_byte(fetch_addr | 20'h1), mem_byte(fetch_addr & ~20'h1)};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [7:0] q[$];
  logic [15:0] m_seg, m_ofs;
  int lfsr = 32'h1ace;
  int last_acc;

  function automatic int rnd();
    lfsr = (lfsr >> 1) ^ (-(lfsr & 1) & 32'hB4BCD35C);
    return lfsr & 255;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xfer_valid = 0; fetch_rdy = 0; out_ready = 0;
    xfer_seg = 0; xfer_ofs = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 fetch_req", fetch_req, 1);
    chk("R1 fetch_addr", fetch_addr, 20'hFFFF0);
    rst_n = 1'b1;
    m_seg = 16'hFFFF; m_ofs = 0; last_acc = -1;
    for (int c = 0; c < 900; c++) begin
      int r1, r2, p_rdy, p_ord;
      logic e_req, acc, e_ov;
      logic [19:0] e_addr;
      logic [7:0] b[$];
      string atag, vtag, btag;
      @(negedge clk);
      r1 = rnd(); r2 = rnd();
      if (c < 300)      begin p_rdy = 180; p_ord = 150; end
      else if (c < 400) begin p_rdy = 200; p_ord = 0;   end
      else if (c < 700) begin p_rdy = 80;  p_ord = 230; end
      else              begin p_rdy = 256; p_ord = 256; end
      fetch_rdy  = (r1 < p_rdy) || (c == 148);
      out_ready  = (r2 < p_ord);
      xfer_valid = (c % 37 == 5) || (c == 148) || (c == 520);
      xfer_seg   = (c == 520) ? 16'hFFFF : 16'(c * 131);
      xfer_ofs   = (c == 520) ? 16'hFFFF : 16'(c * 7);
      #1;
      e_addr = 20'(({4'h0, m_seg} << 4) + {4'h0, m_ofs});
      e_req  = (q.size() <= DEPTH - 2) && !xfer_valid;
      acc    = e_req && fetch_rdy;
      b = {};
      if (m_ofs[0]) b.push_back(mem_byte(e_addr));
      else begin b.push_back(mem_byte(e_addr)); b.push_back(mem_byte(e_addr + 1)); end
      e_ov = !xfer_valid && (q.size() > 0 || acc);
      atag = (last_acc == 1) ? "R5 addr" : (last_acc == 0) ? "R4 addr" : "R2 addr";
      vtag = xfer_valid ? (fetch_rdy ? "R8 out_valid" : "R7 out_valid") : "R10 out_valid";
      btag = (q.size() == 0) ? "R9 out_byte" : "R6 out_byte";
      chk("R3 fetch_req", fetch_req, e_req);
      chk(atag, fetch_addr, e_addr);
      chk(vtag, out_valid, e_ov);
      if (e_ov) chk(btag, out_byte, (q.size() > 0) ? q[0] : b[0]);
      last_acc = -1;
      if (xfer_valid) begin
        q = {}; m_seg = xfer_seg; m_ofs = xfer_ofs;
      end else begin
        if (acc) begin
          foreach (b[i]) q.push_back(b[i]);
          last_acc = m_ofs[0] ? 1 : 0;
          m_ofs = m_ofs + (m_ofs[0] ? 16'd1 : 16'd2);
        end
        if (e_ov && out_ready) void'(q.pop_front());
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule